// File: doc/BRIEF.md
# Width-Merging Register File

This block holds sixteen 64-bit general-purpose registers and lets every port reach a register as a whole quadword or as a narrower slice: a 32-bit doubleword, a 16-bit word, the lowest byte, or the second byte (bits 15:8). One write port and two read ports are provided. Each port carries a register index, a two-bit width code and a high-byte flag. A shared prefix input selects the byte encoding. Without the prefix, byte indices 4 to 7 address the second byte of registers 0 to 3. With the prefix, the same byte indices address the low byte of registers 4 to 7.

Narrow writes merge into the existing register value. A doubleword write is the one exception: it clears the upper half of the register. Reads are combinational and zero-extend the selected slice into bit 0 upward. An access that the selected encoding does not allow is blocked. A blocked write changes nothing and raises an error strobe for one cycle. A blocked read returns zero and raises an error flag.

Top module: `subreg_file`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to zero, and a 64-bit read of any register then returns zero.
- R2: A write with width code 11 replaces all 64 bits. A read with width code 11 returns all 64 bits.
- R3: A write with width code 10 stores the data in bits 31:0 and forces bits 63:32 to zero.
- R4: A write with width code 01 replaces bits 15:0 and leaves bits 63:16 unchanged.
- R5: A byte write (width code 00, high flag 0) to a low-byte target replaces bits 7:0 and leaves bits 63:8 unchanged. With the prefix, this applies to every index 0 to 15. Without the prefix, it applies to indices 0 to 3.
- R6: With the high flag set, width code 00, index 0 to 3 and no prefix, an access targets bits 15:8 of that register. A write leaves all other bits unchanged. The byte value is taken from data bits 7:0.
- R7: Register index order is A=0, C=1, D=2, B=3, SP=4, BP=5, SI=6, DI=7, then 8 to 15. For a byte access with high flag 0, indices 4 to 7 select bits 15:8 of register index-4 when the prefix is absent. When the prefix is present, they select bits 7:0 of register 4 to 7.
- R8: The following accesses are illegal: the high flag with a width other than 8 bits, the high flag with the prefix, the high flag with an index of 4 or more, and a byte access to index 8 to 15 without the prefix. An illegal write changes no register and sets the write error output for the one cycle after the edge. An illegal read returns zero and sets that port's read error output.
- R9: A narrow read returns the selected slice in the low bits, and every bit above the slice is zero.
- R10: A read of a register in the cycle it is written returns the old value. The new value is visible after the clock edge.
- R11: On one register, the write sequence 64-bit 1111111111111111h, 32-bit 22222222h, 16-bit 3333h, 8-bit low 44h leaves the value 0000000022223344h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pfx | input | 1 | Extended-register prefix present; selects the byte encoding for all ports |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_wid | input | 2 | Write width: 00=8, 01=16, 10=32, 11=64 |
| wr_hi | input | 1 | Write targets bits 15:8 |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Previous-cycle write was illegal |
| ra_idx | input | 4 | Read port A index |
| ra_wid | input | 2 | Read port A width |
| ra_hi | input | 1 | Read port A high-byte flag |
| ra_data | output | 64 | Read port A data, zero-extended |
| ra_err | output | 1 | Read port A access illegal |
| rb_idx | input | 4 | Read port B index |
| rb_wid | input | 2 | Read port B width |
| rb_hi | input | 1 | Read port B high-byte flag |
| rb_data | output | 64 | Read port B data, zero-extended |
| rb_err | output | 1 | Read port B access illegal |

## Verification
The hardest case to create is damage outside the target: a bad merge mask or a wrong legacy remap can corrupt bits of another register or other bits of the same register. A plain write-then-read-the-same-slice test cannot see that damage. The stimulus therefore first fills every register with a distinct pattern. It then sweeps every combination of index, width, high flag and prefix. After each write it reads the same slice back and reads all sixteen registers in full. Any bit that moved without cause is caught at the ports.

// File: rtl/subreg_file.sv
module subreg_file #(
  parameter int NREG = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ext_pfx,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [1:0]  wr_wid,
  input  logic        wr_hi,
  input  logic [63:0] wr_data,
  output logic        wr_err,
  input  logic [3:0]  ra_idx,
  input  logic [1:0]  ra_wid,
  input  logic        ra_hi,
  output logic [63:0] ra_data,
  output logic        ra_err,
  input  logic [3:0]  rb_idx,
  input  logic [1:0]  rb_wid,
  input  logic        rb_hi,
  output logic [63:0] rb_data,
  output logic        rb_err
);
  localparam int IDXW = $clog2(NREG);
  localparam logic [2:0] K_LO = 3'd0, K_HI = 3'd1, K_W = 3'd2, K_D = 3'd3, K_Q = 3'd4;

  typedef struct packed {
    logic            ok;
    logic [IDXW-1:0] r;
    logic [2:0]      k;
  } acc_t;

  logic [63:0] regs [NREG];
  acc_t wa, aa, ba;

  function automatic acc_t decode(input logic [IDXW-1:0] idx, input logic [1:0] wid,
                                  input logic hi, input logic pfx);
    acc_t d;
    d.ok = 1'b1;
    d.r  = idx;
    d.k  = K_LO;
    if (wid != 2'b00) begin
      d.ok = !hi;
      d.k  = 3'(wid) + 3'd1;
    end else if (hi) begin
      d.ok = !pfx && (idx < IDXW'(4));
      d.k  = K_HI;
    end else if (!pfx && idx >= IDXW'(4)) begin
      d.ok = idx < IDXW'(8);
      d.r  = idx - IDXW'(4);
      d.k  = K_HI;
    end
    return d;
  endfunction

  function automatic logic [63:0] slice(input logic [63:0] v, input logic [2:0] k);
    case (k)
      K_LO:    return {56'd0, v[7:0]};
      K_HI:    return {56'd0, v[15:8]};
      K_W:     return {48'd0, v[15:0]};
      K_D:     return {32'd0, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                        input logic [2:0] k);
    case (k)
      K_LO:    return {old[63:8], d[7:0]};
      K_HI:    return {old[63:16], d[7:0], old[7:0]};
      K_W:     return {old[63:16], d[15:0]};
      K_D:     return {32'd0, d[31:0]};
      default: return d;
    endcase
  endfunction

  assign wa = decode(wr_idx[IDXW-1:0], wr_wid, wr_hi, ext_pfx);
  assign aa = decode(ra_idx[IDXW-1:0], ra_wid, ra_hi, ext_pfx);
  assign ba = decode(rb_idx[IDXW-1:0], rb_wid, rb_hi, ext_pfx);

  assign ra_data = aa.ok ? slice(regs[aa.r], aa.k) : 64'd0;
  assign ra_err  = !aa.ok;
  assign rb_data = ba.ok ? slice(regs[ba.r], ba.k) : 64'd0;
  assign rb_err  = !ba.ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 64'd0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= wr_en && !wa.ok;
      if (wr_en && wa.ok) regs[wa.r] <= merge(regs[wa.r], wr_data, wa.k);
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (regs[0] == 64'd0 && regs[NREG-1] == 64'd0));

  p_dword_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wa.ok && wa.k == K_D) |=> regs[$past(wa.r)][63:32] == 32'd0);

  p_word_keeps_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wa.ok && wa.k == K_W) |=> regs[$past(wa.r)][63:16] == $past(regs[wa.r][63:16]));

  p_byte_keeps_rest_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wa.ok && wa.k == K_LO) |=> regs[$past(wa.r)][63:8] == $past(regs[wa.r][63:8]));

  p_hibyte_keeps_rest_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wa.ok && wa.k == K_HI) |=>
      (regs[$past(wa.r)][63:16] == $past(regs[wa.r][63:16]) &&
       regs[$past(wa.r)][7:0] == $past(regs[wa.r][7:0])));

  p_bad_write_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wa.ok) |=> (wr_err && regs[$past(wa.r)] == $past(regs[wa.r])));
endmodule

// File: tb/subreg_file_tb_top.sv
module subreg_file_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ext_pfx, wr_en, wr_hi, ra_hi, rb_hi, wr_err, ra_err, rb_err;
  logic [3:0] wr_idx, ra_idx, rb_idx;
  logic [1:0] wr_wid, ra_wid, rb_wid;
  logic [63:0] wr_data, ra_data, rb_data;

  subreg_file dut_i (.clk(clk), .rst(rst), .ext_pfx(ext_pfx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wid(wr_wid), .wr_hi(wr_hi), .wr_data(wr_data), .wr_err(wr_err),
    .ra_idx(ra_idx), .ra_wid(ra_wid), .ra_hi(ra_hi), .ra_data(ra_data), .ra_err(ra_err),
    .rb_idx(rb_idx), .rb_wid(rb_wid), .rb_hi(rb_hi), .rb_data(rb_data), .rb_err(rb_err));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] mdl [16];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bdec(input int idx, input int wid, input int hi, input int pfx,
                      output bit legal, output int r, output int off, output int nb);
    nb = 8 << wid; off = 0; r = idx; legal = 1;
    if (hi != 0) begin
      legal = (wid == 0) && (pfx == 0) && (idx < 4);
      off = 8;
    end else if (wid == 0 && pfx == 0 && idx >= 4) begin
      if (idx < 8) begin r = idx - 4; off = 8; end
      else legal = 0;
    end
  endtask

  function automatic logic [63:0] msk(input int nb);
    return (nb == 64) ? {64{1'b1}} : ((64'd1 << nb) - 64'd1);
  endfunction

  task automatic do_wr(input int idx, input int wid, input int hi, input int pfx,
                       input logic [63:0] d, input string req);
    bit legal; int r, off, nb;
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_wid = 2'(wid); wr_hi = hi[0]; ext_pfx = pfx[0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    bdec(idx, wid, hi, pfx, legal, r, off, nb);
    chk({req, " wr_err"}, {63'd0, wr_err}, {63'd0, !legal});
    if (legal) begin
      if (nb == 32) mdl[r] = d & 64'hFFFF_FFFF;
      else mdl[r] = (mdl[r] & ~(msk(nb) << off)) | ((d & msk(nb)) << off);
    end
  endtask

  task automatic rd(input int port, input int idx, input int wid, input int hi,
                    input int pfx, input string req);
    bit legal; int r, off, nb;
    logic [63:0] e;
    ext_pfx = pfx[0];
    if (port == 0) begin ra_idx = 4'(idx); ra_wid = 2'(wid); ra_hi = hi[0]; end
    else begin rb_idx = 4'(idx); rb_wid = 2'(wid); rb_hi = hi[0]; end
    #1;
    bdec(idx, wid, hi, pfx, legal, r, off, nb);
    e = legal ? ((mdl[r] >> off) & msk(nb)) : 64'd0;
    if (port == 0) begin
      chk({req, " ra_data"}, ra_data, e);
      chk({req, " ra_err"}, {63'd0, ra_err}, {63'd0, !legal});
    end else begin
      chk({req, " rb_data"}, rb_data, e);
      chk({req, " rb_err"}, {63'd0, rb_err}, {63'd0, !legal});
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) rd(0, i, 3, 0, 1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    rst = 1; ext_pfx = 0; wr_en = 0; wr_idx = 0; wr_wid = 0; wr_hi = 0; wr_data = 0;
    ra_idx = 0; ra_wid = 0; ra_hi = 0; rb_idx = 0; rb_wid = 0; rb_hi = 0;
    for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    chk("R1 reset wr_err", {63'd0, wr_err}, 64'd0);
    rst = 0;

    for (int i = 0; i < 16; i++)
      do_wr(i, 3, 0, 1, 64'h0123_4567_89AB_CDEF * 64'(i + 3) ^ 64'hF0E1_D2C3_B4A5_9687, "R2 fill");
    check_all("R2 fill");

    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int w = 0; w < 4; w++)
          for (int i = 0; i < 16; i++) begin
            if (h == 1 && (w != 0 || p == 1 || i >= 4)) tag = "R8";
            else if (w == 0 && h == 0 && p == 0 && i >= 8) tag = "R8";
            else if (w == 3) tag = "R2";
            else if (w == 2) tag = "R3";
            else if (w == 1) tag = "R4";
            else if (h == 1) tag = "R6";
            else if (p == 0 && i >= 4) tag = "R7";
            else tag = "R5";
            do_wr(i, w, h, p, {8{8'(i * 29 + w * 7 + h * 3 + p * 101 + 17)}} ^ 64'h5A5A_0000_FFFF_1234, tag);
            rd(1, i, w, h, p, {tag, " R9 slice"});
            check_all({tag, " full"});
          end

    @(negedge clk);
    wr_en = 1; wr_idx = 5; wr_wid = 3; wr_hi = 0; ext_pfx = 1; wr_data = 64'hDEAD_BEEF_CAFE_F00D;
    ra_idx = 5; ra_wid = 3; ra_hi = 0;
    #1;
    chk("R10 old value", ra_data, mdl[5]);
    @(negedge clk);
    wr_en = 0;
    mdl[5] = 64'hDEAD_BEEF_CAFE_F00D;
    rd(0, 5, 3, 0, 1, "R10 new value");

    do_wr(0, 3, 0, 0, 64'h1111_1111_1111_1111, "R11 q");
    do_wr(0, 2, 0, 0, 64'h2222_2222, "R11 d");
    do_wr(0, 1, 0, 0, 64'h3333, "R11 w");
    do_wr(0, 0, 0, 0, 64'h44, "R11 b");
    rd(0, 0, 3, 0, 0, "R11 model");
    chk("R11 constant", ra_data, 64'h0000_0000_2222_3344);

    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
    check_all("R1 mid reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule